// File: doc/BRIEF.md
# Multiplexed Bus Cycle Capture Sequencer

This block watches an 8-bit microprocessor expansion bus from a fast on-chip clock. The bus address and data bytes reach the block through one shared set of eight input pins. Three external transceivers sit in front of those pins, and each is switched on by its own active-low enable. When the bus phase clock rises, the sequencer switches the transceivers on one after another at fixed clock-cycle offsets. It samples an auxiliary field, the high address byte, the low address byte, and finally a group made of R/W, device-select and the data byte.

The four samples are packed into one record and offered to a downstream FIFO for one cycle. If the FIFO is full, the record is dropped and a sticky overflow flag is set. On a read cycle the block samples the final group earlier, because its data bits are meaningless there. It also pulses a trigger to a separate read responder. Before it starts another bus cycle, it waits for that responder's busy flag to drop, so the two never drive the transceiver controls at the same time.

The phase clock, R/W and device-select inputs pass through a two-flop synchronizer, and every decision is taken on the synchronized copies. In the timings below, edge 1 is the first rising `clk_i` edge at which `phase_i` is high. A, S, W and D are the parameters AUX_DLY, SETTLE, WR_DLY and RD_DLY, with defaults 5, 6, 24 and 6. H is the last edge at which `phase_i` is high.

Top module: `bus_cycle_capture`

## Requirements
- R1: `xcvr_en_no` is active low. Bit 2 enables the high-address transceiver, bit 1 the low-address one and bit 0 the data one. At most one bit is ever low, and the value is 3'b111 after reset and between bus cycles.
- R2: `phase_i`, `rw_i` and `dev_sel_ni` are synchronized by two flops. The auxiliary field `pins_i[5:0]` is sampled at edge A+3, and `xcvr_en_no` becomes 3'b011 at that same edge.
- R3: The high address byte is sampled at edge A+S+3, where `xcvr_en_no` becomes 3'b101. The low address byte is sampled at edge A+2S+3, where it becomes 3'b110.
- R4: On a write cycle (`rw_i` = 0), the final group is sampled at edge A+2S+W+3.
- R5: On a read cycle (`rw_i` = 1), the final group is sampled at edge A+2S+D+3.
- R6: `rec_valid_o` is high for exactly the one cycle that follows the final sample edge. During that cycle `rec_o` = {aux[5:0] in bits 31:26, high byte in 25:18, low byte in 17:10, R/W in bit 9, device-select in bit 8, data in 7:0}.
- R7: `rd_trig_o` pulses for one cycle, in the same cycle as the record, on read cycles only.
- R8: After a read cycle, `xcvr_en_no` returns to 3'b111 at the first edge at which the synchronized phase is low and `resp_busy_i` is low. That is edge H+3, or one edge after busy falls if that is later. On a write cycle `resp_busy_i` is ignored.
- R9: If `fifo_full_i` is high at the final sample edge, no record is pushed and `overflow_o` goes high and stays high until reset.
- R10: `xcvr_en_no` holds 3'b110 from the low-byte sample edge until the return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 1 | Bus phase clock, asynchronous |
| rw_i | input | 1 | Bus R/W, 1 = read, asynchronous |
| dev_sel_ni | input | 1 | Device select, active low, asynchronous |
| pins_i | input | 8 | Shared transceiver output pins |
| xcvr_en_no | output | 3 | Transceiver enables, active low |
| rec_o | output | 32 | Captured bus-cycle record |
| rec_valid_o | output | 1 | Record push strobe to FIFO |
| fifo_full_i | input | 1 | Downstream FIFO full |
| rd_trig_o | output | 1 | Read responder trigger pulse |
| resp_busy_i | input | 1 | Read responder busy |
| overflow_o | output | 1 | Sticky record drop flag |

## Verification
Each result falls due at a fixed edge, counted from the first clock edge that sees `phase_i` high: the three select changes at edges A+3, A+S+3 and A+2S+3, and the record and trigger in the cycle after edge A+2S+W+3 or A+2S+D+3. The return to idle falls due at edge H+3, or one edge after busy drops. The bench drives its inputs on falling clock edges and counts rising edges from the phase rise. At every falling edge it compares the enables, strobe, trigger and overflow flag with values computed from that count. A transceiver model in the bench feeds distinct bytes onto the pins, so a sample taken at the wrong edge shows up as a wrong record field.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_AUX, ST_HI, ST_LO, ST_DAT, ST_FALL} seq_st_e;
  typedef enum logic [2:0] {CAP_NONE, CAP_AUX, CAP_HI, CAP_LO, CAP_DAT} cap_e;
  localparam logic [2:0] EN_IDLE = 3'b111;
  localparam logic [2:0] EN_HI   = 3'b011;
  localparam logic [2:0] EN_LO   = 3'b101;
  localparam logic [2:0] EN_DAT  = 3'b110;
endpackage

// File: rtl/bcc_sync.sv
module bcc_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= d_i[i];
        s2_q[i] <= s1_q[i];
      end
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/bcc_sequencer.sv
module bcc_sequencer
  import bcc_pkg::*;
#(
  parameter int AUX_DLY = 5,
  parameter int SETTLE  = 6,
  parameter int WR_DLY  = 24,
  parameter int RD_DLY  = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       phase_s_i,
  input  logic       rw_s_i,
  input  logic       busy_i,
  output logic [2:0] xcvr_en_no,
  output cap_e       cap_o,
  output logic       rd_trig_o
);
  localparam int MAX_A = (AUX_DLY > SETTLE) ? AUX_DLY : SETTLE;
  localparam int MAX_B = (WR_DLY > RD_DLY) ? WR_DLY : RD_DLY;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_D + 1);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rd_q, rd_d;
  logic             phase_d_q;
  logic             trig_d;
  logic             rise;

  assign rise = phase_s_i & ~phase_d_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    rd_d   = rd_q;
    cap_o  = CAP_NONE;
    trig_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (rise) begin
        st_d  = ST_AUX;
        cnt_d = CNT_W'(AUX_DLY - 1);
      end
      ST_AUX: if (cnt_q == '0) begin
        cap_o = CAP_AUX;
        st_d  = ST_HI;
        cnt_d = CNT_W'(SETTLE - 1);
      end
      ST_HI: if (cnt_q == '0) begin
        cap_o = CAP_HI;
        st_d  = ST_LO;
        cnt_d = CNT_W'(SETTLE - 1);
      end
      ST_LO: if (cnt_q == '0) begin
        cap_o = CAP_LO;
        st_d  = ST_DAT;
        rd_d  = rw_s_i;
        cnt_d = rw_s_i ? CNT_W'(RD_DLY - 1) : CNT_W'(WR_DLY - 1);
      end
      ST_DAT: if (cnt_q == '0) begin
        cap_o  = CAP_DAT;
        trig_d = rd_q;
        st_d   = ST_FALL;
      end
      ST_FALL: if (!phase_s_i && !(rd_q && busy_i)) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      rd_q      <= 1'b0;
      phase_d_q <= 1'b0;
      rd_trig_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      rd_q      <= rd_d;
      phase_d_q <= phase_s_i;
      rd_trig_o <= trig_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_HI:           xcvr_en_no = EN_HI;
      ST_LO:           xcvr_en_no = EN_LO;
      ST_DAT, ST_FALL: xcvr_en_no = EN_DAT;
      default:         xcvr_en_no = EN_IDLE;
    endcase
  end

  AST_ONE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~xcvr_en_no) <= 1); // R1
  AST_TRIG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_trig_o |=> !rd_trig_o); // R7
  AST_WR_NO_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o == CAP_DAT && !rd_q) |=> !rd_trig_o); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FALL && rd_q && busy_i) |=> (xcvr_en_no == EN_DAT)); // R8
endmodule

// File: rtl/bcc_record.sv
module bcc_record
  import bcc_pkg::*;
#(
  parameter int AUX_W  = 6,
  parameter int BYTE_W = 8,
  localparam int REC_W = AUX_W + 3 * BYTE_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cap_e              cap_i,
  input  logic [BYTE_W-1:0] pins_i,
  input  logic              rw_s_i,
  input  logic              sel_s_i,
  input  logic              fifo_full_i,
  output logic [REC_W-1:0]  rec_o,
  output logic              rec_valid_o,
  output logic              overflow_o
);
  logic [AUX_W-1:0]  aux_q;
  logic [BYTE_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aux_q       <= '0;
      hi_q        <= '0;
      lo_q        <= '0;
      rec_o       <= '0;
      rec_valid_o <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      rec_valid_o <= 1'b0;
      unique case (cap_i)
        CAP_AUX: aux_q <= pins_i[AUX_W-1:0];
        CAP_HI:  hi_q  <= pins_i;
        CAP_LO:  lo_q  <= pins_i;
        CAP_DAT: begin
          if (fifo_full_i) overflow_o <= 1'b1;
          else begin
            rec_o       <= {aux_q, hi_q, lo_q, rw_s_i, sel_s_i, pins_i};
            rec_valid_o <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_DROP_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i == CAP_DAT && fifo_full_i) |=> (!rec_valid_o && overflow_o)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o); // R9
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |=> !rec_valid_o); // R6
endmodule

// File: rtl/bus_cycle_capture.sv
module bus_cycle_capture
  import bcc_pkg::*;
#(
  parameter int AUX_DLY = 5,
  parameter int SETTLE  = 6,
  parameter int WR_DLY  = 24,
  parameter int RD_DLY  = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        phase_i,
  input  logic        rw_i,
  input  logic        dev_sel_ni,
  input  logic [7:0]  pins_i,
  output logic [2:0]  xcvr_en_no,
  output logic [31:0] rec_o,
  output logic        rec_valid_o,
  input  logic        fifo_full_i,
  output logic        rd_trig_o,
  input  logic        resp_busy_i,
  output logic        overflow_o
);
  logic [2:0] sync_q;
  cap_e       cap;

  bcc_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({phase_i, rw_i, dev_sel_ni}),
    .q_o   (sync_q)
  );

  bcc_sequencer #(
    .AUX_DLY(AUX_DLY), .SETTLE(SETTLE), .WR_DLY(WR_DLY), .RD_DLY(RD_DLY)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_s_i (sync_q[2]),
    .rw_s_i    (sync_q[1]),
    .busy_i    (resp_busy_i),
    .xcvr_en_no(xcvr_en_no),
    .cap_o     (cap),
    .rd_trig_o (rd_trig_o)
  );

  bcc_record #(.AUX_W(6), .BYTE_W(8)) u_rec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .pins_i     (pins_i),
    .rw_s_i     (sync_q[1]),
    .sel_s_i    (sync_q[0]),
    .fifo_full_i(fifo_full_i),
    .rec_o      (rec_o),
    .rec_valid_o(rec_valid_o),
    .overflow_o (overflow_o)
  );
endmodule

// File: tb/test_bus_cycle_capture.sv
module test_bus_cycle_capture;
  localparam int A = 5, S = 6, W = 24, D = 6;
  localparam int HI_LEN = 70, LO_LEN = 40;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic phase_i = 1'b0, rw_i = 1'b0, dev_sel_ni = 1'b1;
  logic fifo_full_i = 1'b0, resp_busy_i = 1'b0;
  logic [7:0] pins_i;
  logic [2:0] xcvr_en_no;
  logic [31:0] rec_o;
  logic rec_valid_o, rd_trig_o, overflow_o;

  logic [5:0] b_aux = '0;
  logic [7:0] b_hi = '0, b_lo = '0, b_dat = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit exp_ovf = 1'b0;

  always #2 clk = ~clk;

  // transceiver model: whichever enable is low drives the pins
  assign pins_i = (xcvr_en_no == 3'b011) ? b_hi :
                  (xcvr_en_no == 3'b101) ? b_lo :
                  (xcvr_en_no == 3'b110) ? b_dat : {2'b00, b_aux};

  bus_cycle_capture #(.AUX_DLY(A), .SETTLE(S), .WR_DLY(W), .RD_DLY(D)) i_bus_cycle_capture (
    .clk_i(clk), .rst_ni(rst_ni), .phase_i(phase_i), .rw_i(rw_i), .dev_sel_ni(dev_sel_ni),
    .pins_i(pins_i), .xcvr_en_no(xcvr_en_no), .rec_o(rec_o), .rec_valid_o(rec_valid_o),
    .fifo_full_i(fifo_full_i), .rd_trig_o(rd_trig_o), .resp_busy_i(resp_busy_i),
    .overflow_o(overflow_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic bus_cycle(input bit rw, input bit seln, input logic [5:0] aux,
                           input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] dat,
                           input bit full, input int busy_end);
    int dk, endk;
    logic [2:0] es;
    string tg;
    @(negedge clk);
    rw_i = rw; dev_sel_ni = seln; fifo_full_i = full;
    b_aux = aux; b_hi = hi; b_lo = lo; b_dat = dat;
    repeat (4) @(negedge clk);
    phase_i = 1'b1;
    dk = 3 + A + 2 * S + (rw ? D : W);
    endk = HI_LEN + 3;
    if (rw && busy_end + 1 > endk) endk = busy_end + 1;
    for (int k = 1; k <= HI_LEN + LO_LEN; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k < 3 + A)              begin es = 3'b111; tg = "R2"; end
      else if (k < 3 + A + S)     begin es = 3'b011; tg = "R2"; end
      else if (k < 3 + A + 2 * S) begin es = 3'b101; tg = "R3"; end
      else if (k < endk)          begin es = 3'b110; tg = (k < dk) ? "R3" : "R10"; end
      else                        begin es = 3'b111; tg = "R8"; end
      chk(tg, 32'(xcvr_en_no), 32'(es));
      chk("R1", 32'($countones(~xcvr_en_no) <= 1), 32'd1);
      if (k == dk && full) exp_ovf = 1'b1;
      chk((k == dk) ? "R9" : "R6", 32'(rec_valid_o), 32'((k == dk) && !full));
      chk("R7", 32'(rd_trig_o), 32'((k == dk) && rw));
      chk("R9", 32'(overflow_o), 32'(exp_ovf));
      if (k == dk && !full)
        chk(rw ? "R5" : "R4", rec_o, {aux, hi, lo, rw, seln, dat});
      if (busy_end > 0 && k == dk) resp_busy_i = 1'b1;
      if (k == busy_end) resp_busy_i = 1'b0;
      if (k == HI_LEN) phase_i = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 32'(xcvr_en_no), 32'h7);
    chk("R6", 32'(rec_valid_o), 32'd0);
    chk("R9", 32'(overflow_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", 32'(xcvr_en_no), 32'h7);
    // write, device addressed
    bus_cycle(1'b0, 1'b0, 6'h2d, 8'hc0, 8'h8f, 8'h5a, 1'b0, 0);
    // read, no busy
    bus_cycle(1'b1, 1'b0, 6'h13, 8'hc0, 8'h81, 8'h3c, 1'b0, 0);
    // read, busy held past phase fall
    bus_cycle(1'b1, 1'b0, 6'h3f, 8'h12, 8'h34, 8'ha5, 1'b0, 95);
    // write with busy raised: busy ignored
    bus_cycle(1'b0, 1'b1, 6'h01, 8'hfe, 8'h01, 8'h77, 1'b0, 100);
    // read, device not selected, busy released before phase fall
    bus_cycle(1'b1, 1'b1, 6'h2a, 8'h55, 8'haa, 8'hff, 1'b0, 50);
    // FIFO full: drop and overflow
    bus_cycle(1'b0, 1'b0, 6'h0f, 8'h9c, 8'h63, 8'h81, 1'b1, 0);
    // normal push, overflow stays set
    bus_cycle(1'b0, 1'b0, 6'h30, 8'h00, 8'hff, 8'h00, 1'b0, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule